// File: doc/BRIEF.md
# Character LCD 4-bit Write Sequencer

This block is the host side of a character LCD module that is wired with only its upper four data lines. Coming out of reset, it waits for the module's supply to settle. It then sends a fixed preamble of single-strobe nibbles. The preamble returns the module's bus logic to a known state, whatever state the module was left in, and then selects the 4-bit interface. After the preamble it sends one complete Function Set byte. From then on it takes bytes from a valid/ready stream. Each byte is tagged as a command or as display data. The block splits every byte into two nibbles, strobes each nibble on the enable line, and then waits for the module to execute the instruction before it accepts the next byte.

Back-pressure works as follows. A byte is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_byte` and `req_is_data` are captured at that edge, so the producer may change them afterwards. `req_ready` goes low on the acceptance edge. It stays low through both strobes and the whole execution wait for that byte. It is also low from reset until the start-up sequence has finished. A producer that holds `req_valid` high while `req_ready` is low simply waits, and nothing is lost. The execution wait is chosen per byte. The clear-screen and return-home commands get a long wait, and every other write gets a short one. Both waits are parameters in clock cycles and should be sized for the slowest module oscillator.

The module latches on the falling edge of E. The block therefore drives the nibble a set number of cycles before E rises, keeps E high for a set number of cycles, and holds the nibble for a set number of cycles after E falls. Reading back from the module is out of scope, so the read/write line is tied to write.

Top module: `lcd4_host_seq`

## Requirements
- R1: While reset is asserted, `lcd_e` is 0, `req_ready` is 0, `lcd_rw` is 0 and `lcd_d` is 0000.
- R2: After reset, the first E strobe starts no earlier than `PWRUP_CYC` cycles. The first four strobes are single-nibble transfers carrying 0011, 0011, 0011 and then 0010, all with `lcd_rs` = 0. There are at least `INIT_WAIT_CYC` cycles from each of these strobes' E fall to the next E fall.
- R3: After the preamble, `FSET_BYTE` is sent as a command (two nibbles, `lcd_rs` = 0) and its short execution wait passes. Only then does `req_ready` first go high.
- R4: A byte is accepted only on an edge where both `req_valid` and `req_ready` are high. `req_ready` stays low from acceptance until that byte's execution wait has ended. A request held during start-up is stalled and then accepted once, unchanged.
- R5: Each accepted byte produces exactly two E strobes: bits 7..4 on the first and bits 3..0 on the second.
- R6: `lcd_rs` is 1 for a data byte and 0 for a command. It stays constant from acceptance until `req_ready` returns high.
- R7: E is high for exactly `E_HIGH_CYC` cycles. `lcd_d` is stable for at least `SETUP_CYC` cycles before E rises, throughout the high time, and for at least `HOLD_CYC` cycles after E falls.
- R8: After a command byte 0x01, 0x02 or 0x03, `req_ready` returns high no earlier than `LONG_WAIT_CYC` cycles after the second E fall.
- R9: After any other byte, data bytes 0x01 to 0x03 included, `req_ready` returns high at least `SHORT_WAIT_CYC` and at most `SHORT_WAIT_CYC + HOLD_CYC + 6` cycles after the second E fall.
- R10: `lcd_rw` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Byte request present |
| req_ready | output | 1 | Sequencer can take a byte this cycle |
| req_is_data | input | 1 | 1 = display data, 0 = command |
| req_byte | input | 8 | Byte to send |
| lcd_rs | output | 1 | Register select to module |
| lcd_rw | output | 1 | Read/write select, always write (0) |
| lcd_e | output | 1 | Enable strobe, module latches on its fall |
| lcd_d | output | 4 | Module data lines D7..D4 |

## Verification
The assertions assume that all inputs are synchronous to `clk` and free of X after reset. They also assume that every timing parameter is at least 1. Only then is every nibble phase at least one cycle long, so that the width and stability properties have a defined window. Beyond the handshake rule, the properties assume nothing about the producer's behaviour. The bench drives every input on the falling clock edge, so each input holds steady across the sampling edge. It deliberately keeps a request pending through start-up to exercise the stall.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;

  typedef enum logic [2:0] {
    CS_PWR,
    CS_PRE_NIB,
    CS_PRE_WAIT,
    CS_IDLE,
    CS_HI,
    CS_LO,
    CS_EXEC
  } ctrl_state_t;

  typedef enum logic [1:0] {
    SP_IDLE,
    SP_SETUP,
    SP_HIGH,
    SP_HOLD
  } strobe_phase_t;

  localparam logic [3:0] NIB_RESYNC = 4'h3;
  localparam logic [3:0] NIB_GO4    = 4'h2;
  localparam int         PRE_COUNT  = 4;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // Commands that take the slow execution path: clear (0x01), home (0x02/0x03).
  function automatic logic slow_cmd(input logic is_data, input logic [7:0] b);
    return !is_data && (b == 8'h01 || b[7:1] == 7'b0000001);
  endfunction

endpackage

// File: rtl/lcd4_strobe.sv
module lcd4_strobe
  import lcd4_pkg::*;
#(
  parameter int SETUP_CYC  = 8,
  parameter int E_HIGH_CYC = 60,
  parameter int HOLD_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] nib,
  output logic       e,
  output logic [3:0] d,
  output logic       done
);
  localparam int MAXC = max3(SETUP_CYC, E_HIGH_CYC, HOLD_CYC);
  localparam int CW   = $clog2(MAXC + 1) + 1;

  strobe_phase_t phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= SP_IDLE;
      cnt_q   <= '0;
      e       <= 1'b0;
      d       <= 4'h0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase_q != SP_IDLE && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        case (phase_q)
          SP_IDLE: if (start) begin
            d       <= nib;
            cnt_q   <= CW'(SETUP_CYC - 1);
            phase_q <= SP_SETUP;
          end
          SP_SETUP: begin
            e       <= 1'b1;
            cnt_q   <= CW'(E_HIGH_CYC - 1);
            phase_q <= SP_HIGH;
          end
          SP_HIGH: begin
            e       <= 1'b0;
            cnt_q   <= CW'(HOLD_CYC - 1);
            phase_q <= SP_HOLD;
          end
          default: begin
            done    <= 1'b1;
            phase_q <= SP_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/lcd4_wait_timer.sv
module lcd4_wait_timer #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/lcd4_ctrl.sv
module lcd4_ctrl
  import lcd4_pkg::*;
#(
  parameter int         TW             = 24,
  parameter int         PWRUP_CYC      = 5_000_000,
  parameter int         INIT_WAIT_CYC  = 740_000,
  parameter int         SHORT_WAIT_CYC = 6_575,
  parameter int         LONG_WAIT_CYC  = 270_000,
  parameter logic [7:0] FSET_BYTE      = 8'h28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_is_data,
  input  logic [7:0]    req_byte,
  output logic          req_ready,
  output logic          rs,
  output logic          stb_start,
  output logic [3:0]    stb_nib,
  input  logic          stb_done,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  input  logic          tmr_zero
);
  localparam logic [2:0] LAST_STEP = 3'(PRE_COUNT - 1);

  ctrl_state_t state_q;
  logic [2:0]  step_q;
  logic [7:0]  byte_q;
  logic        wait_over;

  // The timer is reloaded one cycle after the load pulse, so ignore its zero flag then.
  assign wait_over = !tmr_load && tmr_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= CS_PWR;
      step_q    <= '0;
      byte_q    <= '0;
      rs        <= 1'b0;
      stb_start <= 1'b0;
      stb_nib   <= 4'h0;
      tmr_load  <= 1'b1;
      tmr_val   <= TW'(PWRUP_CYC);
    end else begin
      stb_start <= 1'b0;
      tmr_load  <= 1'b0;
      case (state_q)
        CS_PWR: if (wait_over) begin
          stb_start <= 1'b1;
          stb_nib   <= NIB_RESYNC;
          state_q   <= CS_PRE_NIB;
        end
        CS_PRE_NIB: if (stb_done) begin
          tmr_load <= 1'b1;
          tmr_val  <= TW'(INIT_WAIT_CYC);
          state_q  <= CS_PRE_WAIT;
        end
        CS_PRE_WAIT: if (wait_over) begin
          stb_start <= 1'b1;
          if (step_q == LAST_STEP) begin
            byte_q  <= FSET_BYTE;
            rs      <= 1'b0;
            stb_nib <= FSET_BYTE[7:4];
            state_q <= CS_HI;
          end else begin
            step_q  <= step_q + 1'b1;
            stb_nib <= (3'(step_q + 1'b1) == LAST_STEP) ? NIB_GO4 : NIB_RESYNC;
            state_q <= CS_PRE_NIB;
          end
        end
        CS_IDLE: if (req_valid) begin
          byte_q    <= req_byte;
          rs        <= req_is_data;
          stb_start <= 1'b1;
          stb_nib   <= req_byte[7:4];
          state_q   <= CS_HI;
        end
        CS_HI: if (stb_done) begin
          stb_start <= 1'b1;
          stb_nib   <= byte_q[3:0];
          state_q   <= CS_LO;
        end
        CS_LO: if (stb_done) begin
          tmr_load <= 1'b1;
          tmr_val  <= slow_cmd(rs, byte_q) ? TW'(LONG_WAIT_CYC) : TW'(SHORT_WAIT_CYC);
          state_q  <= CS_EXEC;
        end
        CS_EXEC: if (wait_over) state_q <= CS_IDLE;
        default: state_q <= CS_PWR;
      endcase
    end
  end

  assign req_ready = (state_q == CS_IDLE);

endmodule

// File: rtl/lcd4_host_seq.sv
module lcd4_host_seq
  import lcd4_pkg::*;
#(
  parameter int         PWRUP_CYC      = 5_000_000,
  parameter int         SETUP_CYC      = 8,
  parameter int         E_HIGH_CYC     = 60,
  parameter int         HOLD_CYC       = 4,
  parameter int         INIT_WAIT_CYC  = 740_000,
  parameter int         SHORT_WAIT_CYC = 6_575,
  parameter int         LONG_WAIT_CYC  = 270_000,
  parameter logic [7:0] FSET_BYTE      = 8'h28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_is_data,
  input  logic [7:0] req_byte,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [3:0] lcd_d
);
  localparam int MAXW = max3(PWRUP_CYC, INIT_WAIT_CYC,
                             max3(SHORT_WAIT_CYC, LONG_WAIT_CYC, 0));
  localparam int TW   = $clog2(MAXW + 1) + 1;

  logic          stb_start;
  logic [3:0]    stb_nib;
  logic          stb_done;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;

  lcd4_ctrl #(
    .TW(TW), .PWRUP_CYC(PWRUP_CYC), .INIT_WAIT_CYC(INIT_WAIT_CYC),
    .SHORT_WAIT_CYC(SHORT_WAIT_CYC), .LONG_WAIT_CYC(LONG_WAIT_CYC),
    .FSET_BYTE(FSET_BYTE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_data(req_is_data),
    .req_byte(req_byte), .req_ready(req_ready), .rs(lcd_rs),
    .stb_start(stb_start), .stb_nib(stb_nib), .stb_done(stb_done),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_zero(tmr_zero)
  );

  lcd4_strobe #(
    .SETUP_CYC(SETUP_CYC), .E_HIGH_CYC(E_HIGH_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_stb (
    .clk(clk), .rst_n(rst_n), .start(stb_start), .nib(stb_nib),
    .e(lcd_e), .d(lcd_d), .done(stb_done)
  );

  lcd4_wait_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  assign lcd_rw = 1'b0;

endmodule

// File: rtl/lcd4_host_seq_chk.sv
module lcd4_host_seq_chk #(
  parameter int E_HIGH_CYC = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       lcd_rs,
  input logic       lcd_e,
  input logic [3:0] lcd_d
);
  logic [15:0] hi_len_q;
  logic [2:0]  rises_q;
  logic        e_d_q;
  logic        seen_ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_len_q     <= '0;
      rises_q      <= '0;
      e_d_q        <= 1'b0;
      seen_ready_q <= 1'b0;
    end else begin
      e_d_q    <= lcd_e;
      hi_len_q <= lcd_e ? hi_len_q + 1'b1 : '0;
      if (req_ready) seen_ready_q <= 1'b1;
      if (req_valid && req_ready) rises_q <= '0;
      else if (lcd_e && !e_d_q && rises_q != 3'd7) rises_q <= rises_q + 1'b1;
    end
  end

  // R7
  e_data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> $stable(lcd_d));

  // R7
  e_fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> $stable(lcd_d));

  // R7
  e_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> (hi_len_q == 16'(E_HIGH_CYC)));

  // R6
  rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(lcd_rs));

  // R4
  ready_vs_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> !req_ready);

  // R5
  two_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_ready) && seen_ready_q) |-> (rises_q == 3'd2));

endmodule

bind lcd4_host_seq lcd4_host_seq_chk #(.E_HIGH_CYC(E_HIGH_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .lcd_rs(lcd_rs), .lcd_e(lcd_e), .lcd_d(lcd_d)
);

// File: tb/sim_lcd4_host_seq.sv
`timescale 1ns/1ps
module sim_lcd4_host_seq;
  localparam int PW = 50;
  localparam int SU = 2;
  localparam int EH = 4;
  localparam int HD = 2;
  localparam int IW = 30;
  localparam int SW = 20;
  localparam int LW = 80;
  localparam logic [7:0] FS = 8'h28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_is_data = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic req_ready, lcd_rs, lcd_rw, lcd_e;
  logic [3:0] lcd_d;

  always #4 clk = ~clk;

  lcd4_host_seq #(
    .PWRUP_CYC(PW), .SETUP_CYC(SU), .E_HIGH_CYC(EH), .HOLD_CYC(HD),
    .INIT_WAIT_CYC(IW), .SHORT_WAIT_CYC(SW), .LONG_WAIT_CYC(LW), .FSET_BYTE(FS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_byte(req_byte), .lcd_rs(lcd_rs),
    .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_d(lcd_d)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // monitor log of E falling edges
  logic [3:0] nib_log [0:63];
  logic       rs_log  [0:63];
  int         fall_cyc[0:63];
  int nfall = 0;
  int rise_cyc0 = -1;
  logic e_prev = 1'b0;
  logic [3:0] d_prev = 4'h0;
  int d_chg_cyc = 0;
  int hi_len = 0;
  int width_bad = 0, setup_bad = 0, hold_bad = 0, rw_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_rw) rw_bad++;
      if (lcd_d != d_prev) begin
        if (nfall > 0 && (cyc - fall_cyc[nfall-1]) < HD) hold_bad++;
        d_chg_cyc = cyc;
      end
      if (!e_prev && lcd_e) begin
        if (rise_cyc0 < 0) rise_cyc0 = cyc;
        if ((cyc - d_chg_cyc) < SU) setup_bad++;
      end
      if (lcd_e) hi_len++;
      if (e_prev && !lcd_e) begin
        if (hi_len != EH) width_bad++;
        hi_len = 0;
        if (nfall < 64) begin
          nib_log[nfall]  = lcd_d;
          rs_log[nfall]   = lcd_rs;
          fall_cyc[nfall] = cyc;
          nfall++;
        end
      end
    end
    e_prev = lcd_e;
    d_prev = lcd_d;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(lcd_e == 1'b0, "R1 e in reset", lcd_e, 0);
    chk(req_ready == 1'b0, "R1 ready in reset", req_ready, 0);
    chk(lcd_rw == 1'b0, "R1 rw in reset", lcd_rw, 0);
    chk(lcd_d == 4'h0, "R1 d in reset", lcd_d, 0);
  endtask

  task automatic wait_ready(output int at);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    at = cyc;
  endtask

  // request held pending through the whole start-up (R4 stall), then checks preamble
  task automatic t_init_stall();
    int rdy;
    logic [3:0] exp_n [0:5];
    exp_n[0] = 4'h3; exp_n[1] = 4'h3; exp_n[2] = 4'h3; exp_n[3] = 4'h2;
    exp_n[4] = FS[7:4]; exp_n[5] = FS[3:0];
    req_valid = 1'b1; req_is_data = 1'b1; req_byte = 8'h41;
    @(negedge clk); rst_n = 1'b1;
    wait_ready(rdy);
    chk(nfall == 6, "R4 no byte accepted during start-up (strobes)", nfall, 6);
    chk(rise_cyc0 >= PW, "R2 power-up delay before first strobe", rise_cyc0, PW);
    for (int i = 0; i < 6; i++) begin
      chk(nib_log[i] == exp_n[i], (i < 4) ? "R2 preamble nibble" : "R3 function set nibble",
          nib_log[i], exp_n[i]);
      chk(rs_log[i] == 1'b0, (i < 4) ? "R2 preamble rs" : "R3 function set rs", rs_log[i], 0);
    end
    for (int i = 0; i < 4; i++)
      chk((fall_cyc[i+1] - fall_cyc[i]) >= IW, "R2 preamble gap",
          fall_cyc[i+1] - fall_cyc[i], IW);
    chk((rdy - fall_cyc[5]) >= SW, "R3 ready after function set wait", rdy - fall_cyc[5], SW);
    // the stalled request is accepted at the next edge
    @(negedge clk); req_valid = 1'b0; req_byte = 8'hFF; req_is_data = 1'b0;
    chk(req_ready == 1'b0, "R4 ready low after acceptance", req_ready, 0);
    wait_ready(rdy);
    chk(nfall == 8, "R4 stalled byte sent once", nfall, 8);
    chk(nib_log[6] == 4'h4 && nib_log[7] == 4'h1, "R5 stalled byte nibbles",
        {nib_log[6], nib_log[7]}, 8'h41);
    chk(rs_log[6] && rs_log[7], "R6 data rs", {rs_log[6], rs_log[7]}, 3);
    chk((rdy - fall_cyc[7]) >= SW && (rdy - fall_cyc[7]) <= SW + HD + 6,
        "R9 short wait after data", rdy - fall_cyc[7], SW);
  endtask

  task automatic t_send(input bit is_data, input logic [7:0] b, input bit slow, input string tag);
    int base, rdy, gap, w;
    base = nfall;
    @(negedge clk);
    req_valid = 1'b1; req_is_data = is_data; req_byte = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_byte = ~b; req_is_data = ~is_data;
    wait_ready(rdy);
    chk(nfall == base + 2, {tag, " R5 two strobes"}, nfall - base, 2);
    chk(nib_log[base] == b[7:4], {tag, " R5 high nibble first"}, nib_log[base], b[7:4]);
    chk(nib_log[base+1] == b[3:0], {tag, " R5 low nibble second"}, nib_log[base+1], b[3:0]);
    chk(rs_log[base] == is_data && rs_log[base+1] == is_data, {tag, " R6 rs"},
        rs_log[base+1], is_data);
    gap = rdy - fall_cyc[base+1];
    w = slow ? LW : SW;
    if (slow) chk(gap >= LW, {tag, " R8 long wait"}, gap, LW);
    else      chk(gap >= SW && gap <= SW + HD + 6, {tag, " R9 short wait"}, gap, SW);
    if (w == 0) $display("unused");
  endtask

  task automatic t_waits();
    t_send(1'b0, 8'h01, 1'b1, "clear cmd");
    t_send(1'b0, 8'h02, 1'b1, "home cmd");
    t_send(1'b0, 8'h03, 1'b1, "home cmd alt");
    t_send(1'b0, 8'h06, 1'b0, "entry cmd");
    t_send(1'b1, 8'h01, 1'b0, "data 01");
    t_send(1'b1, 8'h03, 1'b0, "data 03");
    t_send(1'b0, 8'hC5, 1'b0, "address cmd");
    t_send(1'b1, 8'h5A, 1'b0, "data 5A");
  endtask

  task automatic t_timing();
    chk(width_bad == 0, "R7 E high width", width_bad, 0);
    chk(setup_bad == 0, "R7 setup before E rise", setup_bad, 0);
    chk(hold_bad == 0, "R7 hold after E fall", hold_bad, 0);
    chk(rw_bad == 0, "R10 rw stays low", rw_bad, 0);
  endtask

  initial begin
    t_reset();
    t_init_stall();
    t_waits();
    t_timing();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule